// File: doc/BRIEF.md
# Serial Register Write Port

This block is the receiving end of a three-wire configuration link for a frequency-synthesizer register bank. A host holds an enable line high, toggles a serial clock and presents one data bit per serial clock period. The block samples the data line on rising serial clock edges. It assembles a 31-bit frame made of a direction bit, a register address and a register data word. When the frame is a complete write to a writable register, it updates that register. Every register is presented in parallel on a flat output bus, so the rest of the chip can read its settings without any handshake.

The serial lines are sampled in the system clock domain through two-stage synchronizers, and rising serial clock edges are found by edge detection. The serial clock must therefore be slow compared with the system clock. Register zero is not storage. It always returns a fixed identification word, which also has its own output port. Each accepted write produces a one-cycle strobe, and the target address is shown next to the strobe.

Top module: `serwr_port`

## Requirements
- R1: After reset every writable register (slots 1 to NUM_REGS-1) reads zero, slot 0 and `chipId` read the identification word, and `wrStrobe` is low.
- R2: A frame is sampled on rising serial clock edges while `serEn` is high. The first bit is the direction bit, where 0 means write. The next 6 bits are the address and the last 24 bits are the data word, both most significant bit first. Each serial clock high phase and each low phase lasts at least 3 system clock periods.
- R3: An accepted write loads the data word into the addressed slot and raises `wrStrobe` for exactly one system clock cycle, with `wrAddr` equal to the address. A slot changes value only in a cycle where `wrStrobe` is high.
- R4: A frame whose direction bit is 1 leaves every slot unchanged and raises no strobe.
- R5: A write to address 0 is ignored and raises no strobe. Slot 0 and `chipId` always read the identification word, which is 24'h5C0A17 by default.
- R6: A write to an address at or above NUM_REGS (8 by default) is ignored and raises no strobe.
- R7: If `serEn` falls before the 31st rising serial clock edge, the frame is discarded and no slot changes.
- R8: Lowering `serEn` clears the bit position, so the next frame is aligned to its first bit even after a cut-short frame.
- R9: Rising serial clock edges after the 31st within one enable window are ignored. A frame causes at most one write.
- R10: `wrStrobe` is high right after the third system clock rising edge that follows the 31st rising serial clock edge of an accepted write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serEn | input | 1 | Serial frame enable, active high |
| serClk | input | 1 | Serial clock from the host |
| serData | input | 1 | Serial data from the host |
| regBank | output | NUM_REGS*24 | All register slots, slot i in bits [24*i+23:24*i] |
| chipId | output | 24 | Fixed identification word |
| wrStrobe | output | 1 | One-cycle pulse for each accepted write |
| wrAddr | output | 6 | Address of the most recent accepted write |

## Verification
A bit counter that is off by one would move the decode window. The address and data would come out shifted by one place, so the first write frame would strobe the wrong address or load a doubled value. The scoreboard reports this at that strobe, three system cycles after the final serial edge. A position that fails to clear after a cut-short frame shows up on the following complete frame, as a misplaced write or a missing strobe. A bad acceptance decision, such as a read, a write to address 0 or an out-of-range write getting through, shows up as an unexpected strobe or as a changed slot in the full bank comparison made after every frame.

// File: rtl/serwr_pkg.sv
package serwr_pkg;

  // Per-cycle commands from the control to the datapath
  typedef struct packed {
    logic shift;   // take bitIn into the frame shifter
    logic bitIn;   // synchronized serial data bit
    logic clear;   // enable is low: drop any partial frame
    logic commit;  // this shift completes the frame
  } serwr_strobe_t;

endpackage

// File: rtl/serwr_ctrl.sv
module serwr_ctrl
  import serwr_pkg::*;
#(
  parameter int FRAME_BITS  = 31,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(FRAME_BITS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serEn,
  input  logic             serClk,
  input  logic             serData,
  output serwr_strobe_t    strobes,
  output logic             enSync,
  output logic [CNT_W-1:0] bitCount
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_BITS);

  logic [SYNC_STAGES-1:0] clkPipe;
  logic [SYNC_STAGES-1:0] enPipe;
  logic [SYNC_STAGES-1:0] datPipe;
  logic                   clkLast;
  logic                   clkS;
  logic                   datS;
  logic                   sclkRise;
  logic                   roomLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPipe <= '0;
      enPipe  <= '0;
      datPipe <= '0;
      clkLast <= 1'b0;
    end else begin
      clkPipe <= {clkPipe[SYNC_STAGES-2:0], serClk};
      enPipe  <= {enPipe[SYNC_STAGES-2:0], serEn};
      datPipe <= {datPipe[SYNC_STAGES-2:0], serData};
      clkLast <= clkS;
    end
  end

  assign clkS     = clkPipe[SYNC_STAGES-1];
  assign enSync   = enPipe[SYNC_STAGES-1];
  assign datS     = datPipe[SYNC_STAGES-1];
  assign sclkRise = clkS & ~clkLast;
  assign roomLeft = (bitCount < FULL_CNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCount <= '0;
    end else if (!enSync) begin
      bitCount <= '0;
    end else if (sclkRise && roomLeft) begin
      bitCount <= bitCount + 1'b1;
    end
  end

  always_comb begin
    strobes.clear  = ~enSync;
    strobes.bitIn  = datS;
    strobes.shift  = enSync & sclkRise & roomLeft;
    strobes.commit = enSync & sclkRise & (bitCount == LAST_IDX);
  end

endmodule

// File: rtl/serwr_datapath.sv
module serwr_datapath
  import serwr_pkg::*;
#(
  parameter int              ADDR_W    = 6,
  parameter int              DATA_W    = 24,
  parameter int              NUM_REGS  = 8,
  parameter logic [DATA_W-1:0] CHIP_ID   = 24'h5C0A17,
  parameter logic [DATA_W-1:0] RESET_VAL = '0,
  localparam int FRAME_BITS = 1 + ADDR_W + DATA_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  serwr_strobe_t              strobes,
  output logic [NUM_REGS*DATA_W-1:0] regBank,
  output logic                       wrStrobe,
  output logic [ADDR_W-1:0]          wrAddr
);

  logic [FRAME_BITS-2:0] shiftReg;
  logic [FRAME_BITS-1:0] frameNow;
  logic [ADDR_W-1:0]     frameAddr;
  logic [DATA_W-1:0]     frameData;
  logic                  isWrite;
  logic                  addrOk;
  logic                  accept;

  assign frameNow  = {shiftReg, strobes.bitIn};
  assign isWrite   = ~frameNow[FRAME_BITS-1];
  assign frameAddr = frameNow[DATA_W +: ADDR_W];
  assign frameData = frameNow[DATA_W-1:0];
  assign addrOk    = (frameAddr != '0) && (int'(frameAddr) < NUM_REGS);
  assign accept    = strobes.commit & isWrite & addrOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobes.clear) begin
      shiftReg <= '0;
    end else if (strobes.shift) begin
      shiftReg <= frameNow[FRAME_BITS-2:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrStrobe <= 1'b0;
      wrAddr   <= '0;
    end else begin
      wrStrobe <= accept;
      if (accept) wrAddr <= frameAddr;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
    if (g == 0) begin : g_id
      assign regBank[DATA_W-1:0] = CHIP_ID;
    end else begin : g_rw
      logic [DATA_W-1:0] slotQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          slotQ <= RESET_VAL;
        end else if (accept && (frameAddr == ADDR_W'(g))) begin
          slotQ <= frameData;
        end
      end
      assign regBank[g*DATA_W +: DATA_W] = slotQ;
    end
  end

endmodule

// File: rtl/serwr_port.sv
module serwr_port
  import serwr_pkg::*;
#(
  parameter int                ADDR_W      = 6,
  parameter int                DATA_W      = 24,
  parameter int                NUM_REGS    = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] CHIP_ID     = 24'h5C0A17,
  localparam int FRAME_BITS = 1 + ADDR_W + DATA_W,
  localparam int CNT_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       serEn,
  input  logic                       serClk,
  input  logic                       serData,
  output logic [NUM_REGS*DATA_W-1:0] regBank,
  output logic [DATA_W-1:0]          chipId,
  output logic                       wrStrobe,
  output logic [ADDR_W-1:0]          wrAddr
);

  serwr_strobe_t    strobes;
  logic             enSync;
  logic [CNT_W-1:0] bitCount;

  serwr_ctrl #(
    .FRAME_BITS (FRAME_BITS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .serEn   (serEn),
    .serClk  (serClk),
    .serData (serData),
    .strobes (strobes),
    .enSync  (enSync),
    .bitCount(bitCount)
  );

  serwr_datapath #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .NUM_REGS(NUM_REGS),
    .CHIP_ID (CHIP_ID)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .regBank (regBank),
    .wrStrobe(wrStrobe),
    .wrAddr  (wrAddr)
  );

  assign chipId = regBank[DATA_W-1:0];

endmodule

// File: rtl/serwr_port_chk.sv
module serwr_port_chk #(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 24,
  parameter int NUM_REGS   = 8,
  parameter int FRAME_BITS = 31,
  parameter int CNT_W      = 5
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       wrStrobe,
  input logic [ADDR_W-1:0]          wrAddr,
  input logic [NUM_REGS*DATA_W-1:0] regBank,
  input logic                       enSync,
  input logic [CNT_W-1:0]           bitCount
);

  a_r3_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe);

  a_r3_bank_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !wrStrobe |-> $stable(regBank));

  a_r5_r6_addr_legal: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> (wrAddr != '0 && int'(wrAddr) < NUM_REGS));

  a_r7_commit_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> $past(enSync));

  a_r8_realign: assert property (@(posedge clk) disable iff (!rstN)
    !enSync |=> (bitCount == '0));

  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    int'(bitCount) <= FRAME_BITS);

endmodule

bind serwr_port serwr_port_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .NUM_REGS  (NUM_REGS),
  .FRAME_BITS(FRAME_BITS),
  .CNT_W     (CNT_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrStrobe(wrStrobe),
  .wrAddr  (wrAddr),
  .regBank (regBank),
  .enSync  (enSync),
  .bitCount(bitCount)
);

// File: tb/serwr_port_bench.sv
`timescale 1ns/1ps
module serwr_port_bench;

  localparam int          NREG   = 8;
  localparam int          DW     = 24;
  localparam int          HALF   = 4;
  localparam logic [23:0] EXP_ID = 24'h5C0A17;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serEn = 1'b0;
  logic serClk = 1'b0;
  logic serData = 1'b0;
  logic [NREG*DW-1:0] regBank;
  logic [DW-1:0]      chipId;
  logic               wrStrobe;
  logic [5:0]         wrAddr;

  int checks = 0;
  int failures = 0;
  logic [23:0] model [NREG];
  logic [29:0] expQ [$];

  always #4 clk = ~clk;

  serwr_port u_serwr_port (
    .clk(clk), .rstN(rstN), .serEn(serEn), .serClk(serClk), .serData(serData),
    .regBank(regBank), .chipId(chipId), .wrStrobe(wrStrobe), .wrAddr(wrAddr)
  );

  function automatic logic [23:0] slot(input int i);
    return regBank[i*DW +: DW];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compareBank(input string req);
    for (int i = 0; i < NREG; i++)
      check(slot(i) == model[i], req, $sformatf("slot %0d", i),
            {8'h0, slot(i)}, {8'h0, model[i]});
    check(chipId == EXP_ID, req, "chipId", {8'h0, chipId}, {8'h0, EXP_ID});
  endtask

  // Scoreboard monitor (R3): each strobe must match the queue head
  always @(negedge clk) begin
    if (rstN && wrStrobe) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R3", "unexpected strobe addr", {26'h0, wrAddr}, 32'h0);
      end else begin
        logic [29:0] e;
        e = expQ.pop_front();
        check(wrAddr == e[29:24], "R3", "strobe addr", {26'h0, wrAddr}, {26'h0, e[29:24]});
        check(slot(int'(e[29:24]) % NREG) == e[23:0], "R3", "strobe data",
              {8'h0, slot(int'(e[29:24]) % NREG)}, {8'h0, e[23:0]});
      end
    end
  end

  task automatic sendFrame(input logic rw, input logic [5:0] addr, input logic [23:0] data,
                           input int rises, input bit expectWrite, input string req);
    logic [30:0] frame;
    frame = {rw, addr, data};
    if (expectWrite) expQ.push_back({addr, data});
    @(negedge clk);
    serEn = 1'b1;
    serClk = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < rises; i++) begin
      serData = (i < 31) ? frame[30-i] : 1'b1;
      repeat (HALF) @(negedge clk);
      serClk = 1'b1;
      if (i == 30 && expectWrite) begin
        repeat (3) @(posedge clk);
        #1;
        check(wrStrobe == 1'b1, "R10", "strobe latency", {31'h0, wrStrobe}, 32'h1);
        @(negedge clk);
        repeat (HALF - 3) @(negedge clk);
      end else begin
        repeat (HALF) @(negedge clk);
      end
      serClk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    serEn = 1'b0;
    serData = 1'b0;
    repeat (8) @(negedge clk);
    if (expectWrite) model[addr] = data;
    compareBank(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = 24'h0;
    model[0] = EXP_ID;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset state
    compareBank("R1");
    check(wrStrobe == 1'b0, "R1", "strobe idle", {31'h0, wrStrobe}, 32'h0);

    // R2/R3: accepted writes with varied bit patterns
    sendFrame(1'b0, 6'd1, 24'h123456, 31, 1'b1, "R2");
    sendFrame(1'b0, 6'd7, 24'hFFFFFF, 31, 1'b1, "R3");
    sendFrame(1'b0, 6'd3, 24'h000001, 31, 1'b1, "R2");
    sendFrame(1'b0, 6'd5, 24'hA5A55A, 31, 1'b1, "R2");
    sendFrame(1'b0, 6'd1, 24'h800000, 31, 1'b1, "R3");
    // R4: read request changes nothing
    sendFrame(1'b1, 6'd2, 24'h3C3C3C, 31, 1'b0, "R4");
    // R5: write to the identification slot is ignored
    sendFrame(1'b0, 6'd0, 24'h000000, 31, 1'b0, "R5");
    // R6: addresses beyond the bank
    sendFrame(1'b0, 6'd8, 24'h777777, 31, 1'b0, "R6");
    sendFrame(1'b0, 6'd63, 24'h111111, 31, 1'b0, "R6");
    // R7: frames cut short, including one edge before completion
    sendFrame(1'b0, 6'd4, 24'h0F0F0F, 20, 1'b0, "R7");
    sendFrame(1'b0, 6'd4, 24'h0F0F0F, 30, 1'b0, "R7");
    // R8: next full frame after a cut-short one lands correctly
    sendFrame(1'b0, 6'd4, 24'hC0FFEE, 31, 1'b1, "R8");
    // R9: extra serial edges do not cause a second write or change the data
    sendFrame(1'b0, 6'd6, 24'h5A5A5A, 34, 1'b1, "R9");
    sendFrame(1'b0, 6'd2, 24'hDEAD01, 31, 1'b1, "R9");

    repeat (10) @(negedge clk);
    check(expQ.size() == 0, "R3", "missing strobes", expQ.size(), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule